// File: doc/BRIEF.md
# Multimode Up/Down Timer with Toggle Latch

This block is a parameterised timer/counter, 16 bits wide by default, with four ways of advancing its count. It can step at a prescaled fraction of the system clock. It can do the same while a gate input is at its active level, which is how pulse widths and duty cycles are measured. It can step on chosen edges of an external event input. It can also decode a two-phase quadrature sensor, so that the count follows the sensor's position. In the first three modes a software bit sets the direction. An external direction pin may invert that direction while the block runs. In quadrature mode the decoder sets the direction itself.

Each wrap past all-ones (counting up) or past zero (counting down) raises a one-cycle flag. The same wrap flips an output toggle latch, which can drive a pin or act as a slow clock for other logic. Both external inputs pass through a two-flop synchroniser before any edge is detected. A synchronous load writes the count directly. The quadrature decoder is a four-state machine. Its states are QS_LL, QS_HL, QS_HH and QS_LH, each named for the synchronised levels of A and B. The forward transitions LL→HL, HL→HH, HH→LH and LH→LL each produce one up step. The reverse transitions each produce one down step. The two-bit jumps LL↔HH and HL↔LH move the state without counting. Staying in the same state does nothing.

Top module: `mm_timer`

## Requirements
- R1: After reset, count is 0, ovf and unf are 0 and tgl_out is 0.
- R2: With mode=2'b00 (timer) and run=1, the count steps once for every 8<<psel enabled clocks. psel=0 gives a divide by 8 and psel=7 gives a divide by 1024. The prescaler restarts from zero whenever it is not enabled.
- R3: With mode=2'b01 (gated timer), the prescaled count advances only while the synchronised cnt_in equals gate_pol. While cnt_in differs from gate_pol, the count holds.
- R4: With mode=2'b10 (event counter), each synchronised edge of cnt_in selected by edge_sel steps the count once. The edge_sel encodings are 2'b00 none, 2'b01 rising, 2'b10 falling and 2'b11 both.
- R5: Outside quadrature mode the count goes down when dir_sw XOR (ext_dir_en AND dir_in) is 1, and up otherwise. With ext_dir_en=0, dir_in has no effect.
- R6: With mode=2'b11 (quadrature), A is on cnt_in and B is on dir_in. The level pairs {A,B} 00→10→11→01→00 each count +1, and the reverse order counts −1. The result is four counts per sensor cycle.
- R7: In quadrature mode a two-bit jump (00↔11 or 10↔01) changes the count by nothing.
- R8: A step up from all-ones gives 0 and raises ovf for exactly one cycle. ovf and unf are never high together.
- R9: A step down from 0 gives all-ones and raises unf for exactly one cycle.
- R10: tgl_out inverts on each cycle in which ovf or unf is high, and holds at all other times.
- R11: load=1 writes load_val into the count on the next clock and takes priority over any step in that cycle. A load never raises ovf or unf and never moves tgl_out.
- R12: With run=0 and load=0, the count holds in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 timer, 01 gated timer, 10 event counter, 11 quadrature |
| run | input | 1 | Counting enable |
| psel | input | 3 | Prescale select, divide by 8<<psel |
| edge_sel | input | 2 | Event edges: 00 none, 01 rising, 10 falling, 11 both |
| gate_pol | input | 1 | Active level of the gate in gated mode |
| dir_sw | input | 1 | Software direction, 1 = down |
| ext_dir_en | input | 1 | Lets dir_in invert the direction |
| cnt_in | input | 1 | Gate, event input or quadrature A (asynchronous) |
| dir_in | input | 1 | Direction pin or quadrature B (asynchronous) |
| load | input | 1 | Synchronous load strobe |
| load_val | input | 16 | Value written on load |
| count | output | 16 | Current count |
| ovf | output | 1 | One-cycle overflow flag |
| unf | output | 1 | One-cycle underflow flag |
| tgl_out | output | 1 | Output toggle latch |

## Verification
The bench sweeps all eight prescale settings with a run length that is not a multiple of the divisor. A prescaler off by one clock, or one that does not restart, would leave the count one step off. It covers both gate polarities and checks that the count stays frozen with the gate closed, which a gate wired with the wrong sense would fail. It drives every edge_sel code and the external direction pin both enabled and disabled, and sends full quadrature cycles forwards and backwards, plus the illegal two-bit jumps, which a decoder that misread a jump as a step would count. Wraps at both ends, loads to and from the extremes, and a load held through a prescaler tick show whether a flag is missed or doubled, the latch is left unflipped, or a step wins over a load.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_GATED = 2'b01,
        MODE_COUNT = 2'b10,
        MODE_QUAD  = 2'b11
    } mmt_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } mmt_edge_e;

    // Quadrature phase, encoded as {A, B}
    typedef enum logic [1:0] {
        QS_LL = 2'b00,
        QS_LH = 2'b01,
        QS_HL = 2'b10,
        QS_HH = 2'b11
    } mmt_qstate_e;

endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int PSEL_W    = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << PSEL_W) - 1;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] pcnt_q;
    logic [CNT_W-1:0] limit;

    // Divisor 2**(BASE_LOG2+psel); the largest wraps to all-ones, which is correct
    always_comb begin
        limit = (ONE_C << (BASE_LOG2 + int'(psel))) - ONE_C;
        tick  = en && (pcnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!en || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + ONE_C;
        end
    end

    // Smallest divisor is 8, so two ticks never come back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_idle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pcnt_q == '0));
endmodule

// File: rtl/mmt_quad.sv
module mmt_quad
    import mmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic step,
    output logic down
);
    mmt_qstate_e state_q;
    mmt_qstate_e phase_in;

    assign phase_in = mmt_qstate_e'({a, b});

    // State register: always follows the sampled phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_LL;
        end else begin
            state_q <= phase_in;
        end
    end

    // Outputs: forward LL->HL->HH->LH->LL counts up, reverse counts down
    always_comb begin
        step = 1'b0;
        down = 1'b0;
        unique case (state_q)
            QS_LL: begin
                if (phase_in == QS_HL) step = 1'b1;
                else if (phase_in == QS_LH) begin step = 1'b1; down = 1'b1; end
            end
            QS_HL: begin
                if (phase_in == QS_HH) step = 1'b1;
                else if (phase_in == QS_LL) begin step = 1'b1; down = 1'b1; end
            end
            QS_HH: begin
                if (phase_in == QS_LH) step = 1'b1;
                else if (phase_in == QS_HL) begin step = 1'b1; down = 1'b1; end
            end
            QS_LH: begin
                if (phase_in == QS_LL) step = 1'b1;
                else if (phase_in == QS_HH) begin step = 1'b1; down = 1'b1; end
            end
        endcase
    end

    assert_quad_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(state_q ^ phase_in) == 1));

    assert_quad_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q == $past(phase_in)));
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mmt_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int PSEL_W    = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    input  logic [1:0]        edge_sel,
    input  logic              gate_pol,
    input  logic              dir_sw,
    input  logic              ext_dir_en,
    input  logic              cnt_in,
    input  logic              dir_in,
    input  logic              load,
    input  logic [WIDTH-1:0]  load_val,
    output logic [WIDTH-1:0]  count,
    output logic              ovf,
    output logic              unf,
    output logic              tgl_out
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    logic        cin_s, dir_s, cin_d;
    logic        rise, fall, gate_open;
    logic        presc_en, presc_tick;
    logic        q_step, q_down;
    logic        step_raw, do_step, go_down;
    logic        wrap_up, wrap_dn;
    mmt_mode_e   mode_e;
    mmt_edge_e   edge_e;

    mmt_sync #(.N(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dir_in, cnt_in}),
        .q     ({dir_s, cin_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cin_d <= 1'b0;
        else        cin_d <= cin_s;
    end

    always_comb begin
        mode_e    = mmt_mode_e'(mode);
        edge_e    = mmt_edge_e'(edge_sel);
        rise      = cin_s & ~cin_d;
        fall      = ~cin_s & cin_d;
        gate_open = (cin_s == gate_pol);
        presc_en  = run && ((mode_e == MODE_TIMER) ||
                            ((mode_e == MODE_GATED) && gate_open));
    end

    mmt_prescaler #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (presc_en),
        .psel  (psel),
        .tick  (presc_tick)
    );

    mmt_quad u_quad (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (cin_s),
        .b     (dir_s),
        .step  (q_step),
        .down  (q_down)
    );

    // Step source and direction per mode
    always_comb begin
        step_raw = 1'b0;
        go_down  = dir_sw ^ (ext_dir_en & dir_s);
        unique case (mode_e)
            MODE_TIMER, MODE_GATED: step_raw = presc_tick;
            MODE_COUNT: begin
                unique case (edge_e)
                    EDGE_NONE: step_raw = 1'b0;
                    EDGE_RISE: step_raw = rise;
                    EDGE_FALL: step_raw = fall;
                    EDGE_BOTH: step_raw = rise | fall;
                endcase
            end
            MODE_QUAD: begin
                step_raw = q_step;
                go_down  = q_down;
            end
        endcase
        do_step = run && step_raw && !load;
        wrap_up = do_step && !go_down && (count == CNT_MAX);
        wrap_dn = do_step &&  go_down && (count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            ovf     <= 1'b0;
            unf     <= 1'b0;
            tgl_out <= 1'b0;
        end else begin
            ovf <= wrap_up;
            unf <= wrap_dn;
            if (wrap_up || wrap_dn) tgl_out <= ~tgl_out;
            if (load)            count <= load_val;
            else if (do_step)    count <= go_down ? count - CNT_ONE : count + CNT_ONE;
        end
    end

    assert_ovf_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    assert_unf_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (count == CNT_MAX));

    assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |-> (tgl_out != $past(tgl_out)));

    assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf || unf) |-> $stable(tgl_out));

    assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((count == $past(load_val)) && !ovf && !unf));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> (count == $past(count)));
endmodule

// File: tb/mm_timer_bench.sv
module mm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        run = 1'b0;
    logic [2:0]  psel = 3'd0;
    logic [1:0]  edge_sel = 2'b00;
    logic        gate_pol = 1'b1;
    logic        dir_sw = 1'b0;
    logic        ext_dir_en = 1'b0;
    logic        cnt_in = 1'b0;
    logic        dir_in = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [15:0] count;
    logic        ovf, unf, tgl_out;

    int checks = 0;
    int errors = 0;
    int n_ovf = 0;
    int n_unf = 0;

    always #5 clk = ~clk;

    mm_timer u_mm_timer (
        .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .psel(psel),
        .edge_sel(edge_sel), .gate_pol(gate_pol), .dir_sw(dir_sw),
        .ext_dir_en(ext_dir_en), .cnt_in(cnt_in), .dir_in(dir_in),
        .load(load), .load_val(load_val), .count(count), .ovf(ovf),
        .unf(unf), .tgl_out(tgl_out)
    );

    always @(negedge clk) begin
        if (rst_n && ovf) n_ovf++;
        if (rst_n && unf) n_unf++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        load = 1'b1; load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_in = 1'b1; cycles(3);
            cnt_in = 1'b0; cycles(3);
        end
        cycles(4);
    endtask

    task automatic qstep(input logic a, input logic b);
        cnt_in = a; dir_in = b;
        cycles(4);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int div, n, t0, o0, u0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 flags", {ovf, unf, tgl_out}, 0);

        // R2 timer sweep over all prescale settings
        mode = 2'b00;
        for (int p = 0; p < 8; p++) begin
            psel = p[2:0];
            div = 8 << p;
            n = 3 * div + div / 2 + 1;
            do_load(16'd0);
            run = 1'b1;
            cycles(n);
            run = 1'b0;
            check($sformatf("R2 psel=%0d", p), count, n / div);
        end
        // R5 software down direction
        psel = 3'd0; dir_sw = 1'b1;
        do_load(16'd100);
        run = 1'b1; cycles(16); run = 1'b0;
        check("R5 timer down", count, 98);
        dir_sw = 1'b0;

        // R3 gated timer, both polarities
        mode = 2'b01;
        for (int p = 0; p < 2; p++) begin
            gate_pol = p[0]; cnt_in = p[0];
            cycles(4);
            do_load(16'd0);
            run = 1'b1; cycles(40);
            check($sformatf("R3 open pol=%0d", p), count, 5);
            cnt_in = ~p[0];
            cycles(100);
            check($sformatf("R3 closed pol=%0d", p), count, 5);
            run = 1'b0;
        end

        // R4 event counter, all edge selections
        mode = 2'b10; cnt_in = 1'b0; cycles(4);
        run = 1'b1;
        for (int e = 0; e < 4; e++) begin
            edge_sel = e[1:0];
            do_load(16'd0);
            pulse(5);
            check($sformatf("R4 edge_sel=%0d", e), count, (e == 0) ? 0 : (e == 3) ? 10 : 5);
        end

        // R5 external direction pin
        edge_sel = 2'b01; dir_in = 1'b1; ext_dir_en = 1'b1; cycles(4);
        do_load(16'd10); pulse(3);
        check("R5 ext down", count, 7);
        ext_dir_en = 1'b0;
        do_load(16'd10); pulse(3);
        check("R5 ext ignored", count, 13);
        dir_in = 1'b0; cycles(4);

        // R8 / R9 / R10 wraps
        do_load(16'hFFFE);
        o0 = n_ovf; u0 = n_unf; t0 = tgl_out;
        pulse(1);
        check("R8 no early ovf", n_ovf, o0);
        check("R8 at max", count, 16'hFFFF);
        pulse(1);
        check("R8 wrap to zero", count, 0);
        check("R8 one ovf", n_ovf, o0 + 1);
        check("R10 flip on ovf", tgl_out, !t0);
        dir_sw = 1'b1;
        pulse(1);
        check("R9 wrap to max", count, 16'hFFFF);
        check("R9 one unf", n_unf, u0 + 1);
        check("R10 flip on unf", tgl_out, t0);
        pulse(1);
        check("R9 no extra unf", n_unf, u0 + 1);
        dir_sw = 1'b0;

        // R11 loads raise no flag
        o0 = n_ovf; u0 = n_unf; t0 = tgl_out;
        do_load(16'hFFFF); do_load(16'h0000); cycles(2);
        check("R11 load no flags", n_ovf + n_unf, o0 + u0);
        check("R11 load no toggle", tgl_out, t0);
        // R11 load beats a running prescaler
        mode = 2'b00; psel = 3'd0;
        run = 1'b1; cycles(5);
        load = 1'b1; load_val = 16'd500;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check($sformatf("R11 held load %0d", i), count, 500);
        end
        load = 1'b0; run = 1'b0;

        // R12 run low holds
        mode = 2'b10; edge_sel = 2'b11;
        do_load(16'd33); pulse(4);
        check("R12 counter idle", count, 33);
        mode = 2'b00; cycles(50);
        check("R12 timer idle", count, 33);

        // R6 / R7 quadrature
        mode = 2'b11; cnt_in = 1'b0; dir_in = 1'b0; cycles(4);
        run = 1'b1; dir_sw = 1'b1;
        do_load(16'd0);
        for (int r = 0; r < 3; r++) begin
            qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
        end
        check("R6 forward 12", count, 12);
        qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0); qstep(0, 1);
        check("R6 reverse 5", count, 7);
        qstep(1, 0);
        check("R7 jump 01->10", count, 7);
        qstep(1, 1);
        check("R6 step after jump", count, 8);
        qstep(0, 0);
        check("R7 jump 11->00", count, 8);
        u0 = n_unf;
        do_load(16'd1);
        qstep(0, 1); qstep(1, 1);
        check("R9 quad underflow", count, 16'hFFFF);
        check("R9 quad unf", n_unf, u0 + 1);
        run = 1'b0; dir_sw = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule